// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Master

This block is a synchronous master that runs single-byte read and write accesses on an external static RAM through a narrow multiplexed bus. Eight shared lines carry the low address byte and then the data. An external transparent latch, steered by an address-latch-enable line, keeps the low address after it leaves the shared lines. The high address byte has eight lines of its own. The control strobes for write and read are active low.

A client hands over one request at a time (address, write data and a direction bit) with a valid/ready handshake. The master then steps through the address, latch, strobe and end phases, and the strobe low time is a parameter counted in clocks. A read returns its byte together with a one-cycle done pulse. While the disable input is held, the master parks the bus in a defined safe state. On the way in, it clears the external latch by pulsing the enable line low while the shared lines are at zero.

Top module: `mux_bus_master`

## Requirements
- R1: After reset the master is idle: write strobe, read strobe and latch enable are high, the shared lines are driven (output enable 1) with 0x00, the high address lines are 0x00 and ready is 1 while disable is low.
- R2: In the first cycle after a request is accepted, the shared lines carry address bits 7:0 and the high lines carry bits 15:8 with latch enable high. In the next cycle latch enable is low and the low address byte is still on the shared lines.
- R3: Latch enable stays low from its fall until the last cycle of the access. It is high again in the first cycle after that, and at that moment both strobes are high.
- R4: In a write, the data byte is on the shared lines in the cycle before the write strobe falls. The write strobe is low for exactly STROBE_CYC cycles, and the data byte stays on the lines for one cycle after the strobe rises.
- R5: In a read, the read strobe is low for exactly STROBE_CYC cycles. The shared-line output enable is 0 from the first cycle of the low strobe through the cycle after the strobe rises, and it is 1 again once the master is idle.
- R6: Read data is the value on the shared input lines during the last cycle of the low read strobe. It appears on the response data output while done is high, and done is high for exactly one cycle.
- R7: Ready is low from the cycle after acceptance until the access completes. Done is high in cycle 3+STROBE_CYC (read) or 4+STROBE_CYC (write), counting the first cycle after the accepting edge as cycle 1. Ready returns to 1 in the next cycle.
- R8: The write and read strobes are never low together, and the master never drives the shared lines while the read strobe is low.
- R9: When disable is high in the idle state, the master drives latch enable high for one cycle with the shared and high lines at 0x00, then low for one cycle, then high again. It stays in that parked state with ready low for as long as disable is held.
- R10: A disable that arrives during an access takes effect only after the access has completed, including its done pulse. In the idle state, disable takes priority over a request that arrives at the same time, and no access starts.
- R11: When disable falls while parked, the master is idle with ready 1 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dis_i | input | 1 | Park the bus in the safe state while high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Master can accept a request |
| req_addr | input | 16 | Byte address |
| req_wdata | input | 8 | Write data |
| req_write | input | 1 | 1 = write, 0 = read |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Read data, valid with rsp_done |
| ad_o | output | 8 | Shared lines, output value |
| ad_oe | output | 1 | Shared lines output enable |
| ad_i | input | 8 | Shared lines, input value |
| addr_hi_o | output | 8 | High address byte lines |
| ale_o | output | 1 | Latch enable (latch transparent while high) |
| wr_n_o | output | 1 | Write strobe, active low |
| rd_n_o | output | 1 | Read strobe, active low |

## Verification
Any wrong phase state shows up at the pins in the same cycle. The bench model predicts every pin on every clock, so a skipped data phase, an extra strobe cycle or an early return of latch enable is reported within one cycle. A wrong captured address or a wrong sampling point does not show up as a pin fault. It shows up as the wrong byte at read-back, when done rises. For that reason the bench keeps its own shadow of the RAM, separate from the behavioural RAM on the bus, and compares each byte that is read.

// File: rtl/mux_bus_pkg.sv
package mux_bus_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_LATCH,
    ST_DATA,
    ST_STROBE,
    ST_END,
    ST_CLR_SET,
    ST_CLR_FALL,
    ST_OFF
  } mb_state_e;

  // Cycles from the accepting edge until done has been shown once.
  function automatic int unsigned access_len(input logic is_wr, input int unsigned strobe);
    return 3 + strobe + (is_wr ? 1 : 0);
  endfunction

  function automatic logic in_access(input mb_state_e s);
    return (s == ST_ADDR) || (s == ST_LATCH) || (s == ST_DATA) ||
           (s == ST_STROBE) || (s == ST_END);
  endfunction

endpackage

// File: rtl/mb_strobe_timer.sv
module mb_strobe_timer #(
  parameter int unsigned STROBE_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_strobe,
  output logic last
);
  localparam int unsigned CW = (STROBE_CYC > 1) ? $clog2(STROBE_CYC) : 1;
  localparam logic [CW-1:0] LOAD = CW'(STROBE_CYC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= LOAD;
    else if (!in_strobe) cnt <= LOAD;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign last = in_strobe && (cnt == '0);

  // R4/R5: a strobe phase that has not reached its count continues
  p_strobe_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_strobe && !last) |=> in_strobe);

endmodule

// File: rtl/mb_sequencer.sv
module mb_sequencer
  import mux_bus_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      dis_i,
  input  logic      req_fire,
  input  logic      wr_q,
  input  logic      strobe_last,
  output mb_state_e state,
  output logic      ready
);
  mb_state_e nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:     if (dis_i) nxt = ST_CLR_SET;
                   else if (req_fire) nxt = ST_ADDR;
      ST_ADDR:     nxt = ST_LATCH;
      ST_LATCH:    nxt = wr_q ? ST_DATA : ST_STROBE;
      ST_DATA:     nxt = ST_STROBE;
      ST_STROBE:   if (strobe_last) nxt = ST_END;
      ST_END:      nxt = ST_IDLE;
      ST_CLR_SET:  nxt = ST_CLR_FALL;
      ST_CLR_FALL: nxt = ST_OFF;
      ST_OFF:      if (!dis_i) nxt = ST_IDLE;
      default:     nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end

  assign ready = (state == ST_IDLE) && !dis_i;

  // R9: the parked state is held while disable stays high
  p_off_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_OFF && dis_i) |=> (state == ST_OFF));
  // R10: parking begins only from idle, never in the middle of an access
  p_dis_from_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_CLR_SET) |-> ($past(state) == ST_IDLE));
  // R11: release of disable returns to idle on the next edge
  p_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_OFF && !dis_i) |=> (state == ST_IDLE));

endmodule

// File: rtl/mb_pin_decode.sv
module mb_pin_decode
  import mux_bus_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8
) (
  input  mb_state_e          state,
  input  logic               wr_q,
  input  logic [ADDR_W-1:0]  addr_q,
  input  logic [DATA_W-1:0]  wdata_q,
  output logic [DATA_W-1:0]  ad_o,
  output logic               ad_oe,
  output logic [ADDR_W-DATA_W-1:0] addr_hi_o,
  output logic               ale_o,
  output logic               wr_n_o,
  output logic               rd_n_o,
  output logic               done
);
  logic data_phase;

  assign data_phase = wr_q && ((state == ST_DATA) || (state == ST_STROBE) || (state == ST_END));

  always_comb begin
    if (data_phase)            ad_o = wdata_q;
    else if (in_access(state)) ad_o = addr_q[DATA_W-1:0];
    else                       ad_o = '0;
  end

  assign addr_hi_o = in_access(state) ? addr_q[ADDR_W-1:DATA_W] : '0;
  assign ale_o     = !((state == ST_LATCH) || (state == ST_DATA) || (state == ST_STROBE) ||
                       (state == ST_END) || (state == ST_CLR_FALL));
  assign wr_n_o    = !((state == ST_STROBE) && wr_q);
  assign rd_n_o    = !((state == ST_STROBE) && !wr_q);
  assign ad_oe     = !(!wr_q && ((state == ST_STROBE) || (state == ST_END)));
  assign done      = (state == ST_END);

endmodule

// File: rtl/mux_bus_master.sv
module mux_bus_master
  import mux_bus_pkg::*;
#(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned STROBE_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dis_i,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              req_write,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [DATA_W-1:0] ad_o,
  output logic              ad_oe,
  input  logic [DATA_W-1:0] ad_i,
  output logic [ADDR_W-DATA_W-1:0] addr_hi_o,
  output logic              ale_o,
  output logic              wr_n_o,
  output logic              rd_n_o
);
  localparam int unsigned HI_W = ADDR_W - DATA_W;

  mb_state_e         state;
  logic              req_fire;
  logic              strobe_last;
  logic              in_strobe;
  logic              rd_sample;
  logic              wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;

  assign req_fire  = req_valid && req_ready;
  assign in_strobe = (state == ST_STROBE);
  assign rd_sample = strobe_last && !wr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (req_fire) begin
      wr_q    <= req_write;
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         rsp_rdata <= '0;
    else if (rd_sample) rsp_rdata <= ad_i;
  end

  mb_strobe_timer #(.STROBE_CYC(STROBE_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .in_strobe(in_strobe), .last(strobe_last)
  );

  mb_sequencer u_seq (
    .clk(clk), .rst_n(rst_n), .dis_i(dis_i), .req_fire(req_fire), .wr_q(wr_q),
    .strobe_last(strobe_last), .state(state), .ready(req_ready)
  );

  mb_pin_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
    .state(state), .wr_q(wr_q), .addr_q(addr_q), .wdata_q(wdata_q),
    .ad_o(ad_o), .ad_oe(ad_oe), .addr_hi_o(addr_hi_o), .ale_o(ale_o),
    .wr_n_o(wr_n_o), .rd_n_o(rd_n_o), .done(rsp_done)
  );

  // R8: strobes are mutually exclusive
  p_strobes_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(!wr_n_o && !rd_n_o));
  // R8: no drive on the shared lines while the memory may drive them
  p_no_contention_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n_o |-> !ad_oe);
  // R5: output enable still off in the cycle after the read strobe rises
  p_rd_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_n_o) |-> !ad_oe);
  // R4: the write strobe falls only behind a latched address
  p_wr_after_latch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_n_o) |-> (!ale_o && $past(!ale_o)));
  // R3: latch enable returns high only with both strobes inactive
  p_ale_rise_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ale_o) |-> (wr_n_o && rd_n_o));
  // R6: done is a single-cycle pulse
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);
  // R7: ready drops after acceptance
  p_busy_after_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire |=> !req_ready);
  // R2: the high address is stable through the whole access
  p_hi_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ale_o && !rsp_done && !$rose(ale_o)) |=> $stable(addr_hi_o));

  initial begin
    if (HI_W < 1 || STROBE_CYC < 1)
      $display("mux_bus_master: parameter out of range");
  end

endmodule

// File: tb/mux_bus_master_tb.sv
module mux_bus_master_tb;
  import mux_bus_pkg::*;

  localparam int CLK_P = 10;
  localparam int STB   = 3;

  logic clk = 0, rst_n = 0, dis_i = 0;
  logic req_valid = 0, req_write = 0;
  logic [15:0] req_addr = 0;
  logic [7:0]  req_wdata = 0;
  logic req_ready, rsp_done, ad_oe, ale_o, wr_n_o, rd_n_o;
  logic [7:0] rsp_rdata, ad_o, ad_i, addr_hi_o;

  int checks = 0, fails = 0, wdog = 0;

  always #(CLK_P/2) clk = ~clk;

  mux_bus_master #(.STROBE_CYC(STB)) u_dut (
    .clk(clk), .rst_n(rst_n), .dis_i(dis_i), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_write(req_write),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .ad_o(ad_o), .ad_oe(ad_oe), .ad_i(ad_i),
    .addr_hi_o(addr_hi_o), .ale_o(ale_o), .wr_n_o(wr_n_o), .rd_n_o(rd_n_o)
  );

  // ---------- bus-side RAM and external latch ----------
  logic [7:0] busmem [int];
  logic [7:0] latch_q = 0;
  logic [7:0] rd_byte = 0;
  assign ad_i = rd_n_o ? 8'h00 : rd_byte;

  function automatic logic [7:0] fill(input int a);
    return 8'(a) ^ 8'(a >> 8) ^ 8'h3C;
  endfunction

  // ---------- reference model ----------
  logic [7:0] shadow [int];
  int   m_st = 0;           // 0 idle, 1 access, 2 clr high, 3 clr low, 4 parked
  int   m_t = 0, m_len = 0;
  logic m_wr = 0;
  logic [15:0] m_addr = 0;
  logic [7:0]  m_wd = 0;

  function automatic logic [7:0] ref_read(input int a);
    return shadow.exists(a) ? shadow[a] : fill(a);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) m_st = 0;
    else case (m_st)
      0: if (dis_i) m_st = 2;
         else if (req_valid) begin
           m_st = 1; m_t = 0; m_wr = req_write; m_addr = req_addr; m_wd = req_wdata;
           m_len = STB + 3 + (req_write ? 1 : 0);
           if (req_write) shadow[int'(req_addr)] = req_wdata;
         end
      1: begin m_t++; if (m_t == m_len) m_st = 0; end
      2: m_st = 3;
      3: m_st = 4;
      4: if (!dis_i) m_st = 0;
      default: m_st = 0;
    endcase
  end

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------- per-cycle comparison and bus RAM ----------
  always @(negedge clk) begin
    logic e_ale, e_oe, e_wr, e_rd, e_done, e_rdy;
    logic [7:0] e_ad, e_hi;
    string tg;
    if (rst_n) begin
      e_rdy = (m_st == 0) && !dis_i;
      e_wr = 1; e_rd = 1; e_oe = 1; e_done = 0; e_ale = 1; e_ad = 0; e_hi = 0;
      tg = (m_st == 0) ? "R1" : "R9";
      if (m_st == 3) e_ale = 0;
      if (m_st == 1) begin
        e_hi = m_addr[15:8];
        e_ad = m_addr[7:0];
        e_ale = (m_t == 0);
        e_done = (m_t == m_len - 1);
        if (m_wr) begin
          if (m_t >= 2) e_ad = m_wd;
          e_wr = !(m_t >= 3 && m_t < 3 + STB);
          tg = (m_t < 2) ? "R2" : "R4";
        end else begin
          e_rd = !(m_t >= 2 && m_t < 2 + STB);
          e_oe = (m_t < 2);
          tg = (m_t < 2) ? "R2" : "R5";
        end
      end
      chk(req_ready === e_rdy, (m_st == 4 || m_st == 2 || m_st == 3) ? "R9" : "R7", int'(req_ready), int'(e_rdy));
      chk(ale_o === e_ale, (m_st == 1) ? "R3" : tg, int'(ale_o), int'(e_ale));
      chk(wr_n_o === e_wr, tg, int'(wr_n_o), int'(e_wr));
      chk(rd_n_o === e_rd, tg, int'(rd_n_o), int'(e_rd));
      chk(ad_oe === e_oe, tg, int'(ad_oe), int'(e_oe));
      if (e_oe) chk(ad_o === e_ad, tg, int'(ad_o), int'(e_ad));
      chk(addr_hi_o === e_hi, tg, int'(addr_hi_o), int'(e_hi));
      chk(rsp_done === e_done, "R7", int'(rsp_done), int'(e_done));
      if (e_done && !m_wr)
        chk(rsp_rdata === ref_read(int'(m_addr)), "R6", int'(rsp_rdata), int'(ref_read(int'(m_addr))));
      chk(!(!wr_n_o && !rd_n_o) && !(!rd_n_o && ad_oe), "R8", int'({wr_n_o, rd_n_o, ad_oe}), 0);
    end
    // bus RAM
    if (ale_o) latch_q = ad_o;
    if (!wr_n_o && ad_oe) busmem[int'({addr_hi_o, latch_q})] = ad_o;
    rd_byte = busmem.exists(int'({addr_hi_o, latch_q})) ? busmem[int'({addr_hi_o, latch_q})]
                                                       : fill(int'({addr_hi_o, latch_q}));
  end

  // ---------- stimulus ----------
  task automatic access(input logic [15:0] a, input logic [7:0] d, input logic w);
    int n;
    @(posedge clk); #1;
    req_valid = 1; req_addr = a; req_wdata = d; req_write = w;
    do @(negedge clk); while (!req_ready);
    @(posedge clk); #1;
    req_valid = 0;
    n = 0;
    do begin @(negedge clk); n++; end while (!rsp_done && n < 50);
    // R7: completion latency
    chk(n == STB + 3 + (w ? 1 : 0), "R7", n, STB + 3 + (w ? 1 : 0));
    @(negedge clk);
    chk(req_ready === 1'b1, "R7", int'(req_ready), 1);
  endtask

  always @(negedge clk) begin
    wdog++;
    if (wdog > 100000) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R1: reset state
    chk(req_ready && ale_o && wr_n_o && rd_n_o && ad_oe && ad_o == 0 && addr_hi_o == 0,
        "R1", int'({req_ready, ale_o, wr_n_o, rd_n_o, ad_oe}), 5'h1F);

    access(16'h1234, 8'hA5, 1);
    access(16'h1234, 8'h00, 0);
    access(16'hBEEF, 8'h00, 0);
    access(16'h0000, 8'h5A, 1);
    access(16'hFFFF, 8'hC3, 1);
    access(16'h0000, 8'h00, 0);
    access(16'hFFFF, 8'h00, 0);
    for (int k = 0; k < 16; k++) access(16'(1 << k), 8'(k * 17 + 1), 1);
    for (int k = 0; k < 16; k++) access(16'(1 << k), 8'h00, 0);

    // R9: disable from idle, held for several cycles
    @(posedge clk); #1 dis_i = 1;
    @(negedge clk);
    chk(req_ready === 1'b0, "R9", int'(req_ready), 0);
    repeat (6) @(negedge clk);
    chk(ale_o && wr_n_o && rd_n_o && ad_o == 0 && !req_ready, "R9",
        int'({ale_o, wr_n_o, rd_n_o, req_ready}), 4'hE);
    @(posedge clk); #1 dis_i = 0;
    @(negedge clk);
    chk(req_ready === 1'b0, "R11", int'(req_ready), 0);
    @(negedge clk);
    // R11: idle again one cycle after release
    chk(req_ready === 1'b1, "R11", int'(req_ready), 1);

    // R10: disable together with a request in idle: no access starts
    @(posedge clk); #1 dis_i = 1; req_valid = 1; req_write = 1; req_addr = 16'h4444; req_wdata = 8'h99;
    repeat (4) begin
      @(negedge clk);
      chk(wr_n_o === 1'b1, "R10", int'(wr_n_o), 1);
    end
    @(posedge clk); #1 req_valid = 0; dis_i = 0;
    repeat (2) @(negedge clk);

    // R10: disable during a read is deferred until done
    @(posedge clk); #1 req_valid = 1; req_write = 0; req_addr = 16'h1234;
    @(posedge clk); #1 req_valid = 0; dis_i = 1;
    begin
      int n = 0; logic seen = 0;
      while (n < 20) begin
        @(negedge clk); n++;
        if (rsp_done) seen = 1;
      end
      chk(seen, "R10", int'(seen), 1);
    end
    @(posedge clk); #1 dis_i = 0;
    repeat (2) @(negedge clk);
    access(16'h0080, 8'h00, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule